// File: doc/BRIEF.md
# SMBus Register Client with Strap-Selected Address

This block is the serial front end of a sensor-style register file. It watches the two-wire SMBus lines using a fast system clock. Both lines go through a short synchronizer chain. From the synchronized lines it finds the edges that frame a transaction. It then collects the address byte and checks the 7-bit address against one entry of a fixed eight-entry table. A 3-bit strap code, captured once after reset, picks that entry.

On a match the client acknowledges. In a write, the first data byte sets a register pointer and every later byte is written through a simple register port. In a read, the client returns the register at the pointer. The pointer steps by one after every byte written or read.

The client only ever pulls the data line low through an open-drain enable. It has no clock output at all, so it can never hold the clock low. The host may hold the clock in either state for as long as it likes.

Data streams out of the register port with no handshake. The bus cannot be told to wait, so the register side offers no back-pressure. A write is a single-cycle `reg_we` pulse that must be taken in that cycle. `reg_rdata` must show the register at `reg_ptr` combinationally in the same cycle.

Top module: `smb_strap_client`

## Requirements
- R1: A falling data line while the synchronized clock is high starts reception of an address byte from any state. A start during a transaction (repeated start) behaves the same way, and the pointer keeps its value.
- R2: Bits are taken on clock rising edges, most significant bit first. The first byte after a start is a 7-bit address followed by a direction bit: 0 means the host writes and 1 means the host reads.
- R3: Strap codes 0 to 7 select the addresses 0x4C, 0x4D, 0x4E, 0x4F, 0x49, 0x4A, 0x4B and 0x18, in that order.
- R4: The strap code is captured once, in the first cycle after reset, and later changes on `strap_i` have no effect.
- R5: On an address match the client pulls the data line low for the whole ninth clock. On a mismatch it never pulls the line low until the next start or stop.
- R6: In a write, the client acknowledges every data byte. The first data byte loads the pointer. Each later byte gives one `reg_we` pulse carrying the pointer and that byte, and the pointer then steps by one.
- R7: In a read, each byte is taken from `reg_rdata` at the current pointer and sent most significant bit first, and the pointer then steps by one, wrapping from 0xFF to 0x00. During the host's acknowledge clock the client leaves the line free.
- R8: After the host answers a read byte with a not-acknowledge (line high), the client pulls the line low no more until the next start.
- R9: A rising data line while the clock is high (stop) returns the client to idle from any state and releases the line. A byte cut short by a stop writes nothing.
- R10: The client pulls the data line low only starting from a cycle in which the synchronized clock is low.
- R11: If the synchronized clock stays high for `IDLE_CYC` consecutive cycles, the client releases the line and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Address select code, captured after reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 leaves it free |
| reg_ptr | output | 8 | Register pointer, also the address for reads and writes |
| reg_wdata | output | 8 | Write data, valid while `reg_we` is high |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_ptr`, combinational |

## Verification
The bench builds the block with two synchronizer stages and an `IDLE_CYC` of 40. These values keep one bus bit to twelve system cycles, and a bus stall can outlast the idle limit within a short run.

At that speed the bench can sweep every strap code against every table address. It can also sweep all 128 address values for one strap code. The 8-bit pointer is small enough that a read can be walked across its wrap from 0xFF to 0x00.

// File: rtl/smbc_pkg.sv
package smbc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 7;
  localparam int STRAP_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_SKIP
  } link_st_t;

  function automatic logic [ADR_W-1:0] strap_addr(input logic [STRAP_W-1:0] code);
    case (code)
      3'd0: strap_addr = 7'h4C;
      3'd1: strap_addr = 7'h4D;
      3'd2: strap_addr = 7'h4E;
      3'd3: strap_addr = 7'h4F;
      3'd4: strap_addr = 7'h49;
      3'd5: strap_addr = 7'h4A;
      3'd6: strap_addr = 7'h4B;
      default: strap_addr = 7'h18;
    endcase
  endfunction
endpackage

// File: rtl/smbc_sync.sv
module smbc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= '1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/smbc_cond.sv
module smbc_cond #(
  parameter int IDLE_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic idle_to
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic          scl_q, sda_q;
  logic [IW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise  = !scl_q && scl_s;
  assign scl_fall  = scl_q && !scl_s;
  assign start_det = scl_q && scl_s && sda_q && !sda_s;
  assign stop_det  = scl_q && scl_s && !sda_q && sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       hi_cnt <= '0;
    else if (!scl_s)                  hi_cnt <= '0;
    else if (hi_cnt != IW'(IDLE_CYC)) hi_cnt <= hi_cnt + 1'b1;

  assign idle_to = scl_s && (hi_cnt == IW'(IDLE_CYC - 1));
endmodule

// File: rtl/smbc_addr_sel.sv
module smbc_addr_sel
  import smbc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [ADR_W-1:0]   own_addr,
  output logic               addr_locked
);
  logic [STRAP_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_q      <= '0;
      addr_locked <= 1'b0;
    end else if (!addr_locked) begin
      code_q      <= strap_i;
      addr_locked <= 1'b1;
    end

  assign own_addr = strap_addr(code_q);
endmodule

// File: rtl/smbc_link.sv
module smbc_link
  import smbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              idle_to,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_ptr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam int CW = $clog2(BYTE_W + 1);

  link_st_t          st;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              is_addr, rd_dir, have_ptr, nack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      is_addr <= 1'b0; rd_dir <= 1'b0; have_ptr <= 1'b0; nack <= 1'b0;
      sda_oe <= 1'b0; reg_ptr <= '0; reg_wdata <= '0; reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) reg_ptr <= reg_ptr + 1'b1;
      if (stop_det || idle_to) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st       <= ST_RX;
        is_addr  <= 1'b1;
        have_ptr <= 1'b0;
        cnt      <= '0;
        sda_oe   <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(BYTE_W)) begin
              cnt <= '0;
              if (is_addr) begin
                if (sh[BYTE_W-1:1] == own_addr) begin
                  rd_dir  <= sh[0];
                  is_addr <= 1'b0;
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                end else begin
                  st <= ST_SKIP;
                end
              end else begin
                if (!have_ptr) begin
                  reg_ptr  <= sh;
                  have_ptr <= 1'b1;
                end else begin
                  reg_wdata <= sh;
                  reg_we    <= 1'b1;
                end
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_dir) begin
                tx      <= reg_rdata;
                sda_oe  <= ~reg_rdata[BYTE_W-1];
                reg_ptr <= reg_ptr + 1'b1;
                st      <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CW'(BYTE_W)) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (nack) begin
                st <= ST_SKIP;
              end else begin
                tx      <= reg_rdata;
                sda_oe  <= ~reg_rdata[BYTE_W-1];
                reg_ptr <= reg_ptr + 1'b1;
                st      <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/smb_strap_client.sv
module smb_strap_client
  import smbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYC    = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [BYTE_W-1:0]  reg_ptr,
  output logic [BYTE_W-1:0]  reg_wdata,
  output logic               reg_we,
  input  logic [BYTE_W-1:0]  reg_rdata
);
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det, idle_to;
  logic [ADR_W-1:0] own_addr;
  logic             addr_locked;

  smbc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  smbc_cond #(.IDLE_CYC(IDLE_CYC)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .idle_to(idle_to)
  );

  smbc_addr_sel u_addr (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
    .own_addr(own_addr), .addr_locked(addr_locked)
  );

  smbc_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .idle_to(idle_to), .own_addr(own_addr), .reg_rdata(reg_rdata),
    .sda_oe(sda_oe), .reg_ptr(reg_ptr), .reg_wdata(reg_wdata), .reg_we(reg_we)
  );
endmodule

// File: rtl/smbc_check.sv
module smbc_check (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       stop_det,
  input logic       idle_to,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_ptr,
  input logic [6:0] own_addr,
  input logic       addr_locked
);
  AST_OE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_to |=> !sda_oe); // R11
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_ptr == 8'($past(reg_ptr) + 8'd1)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_locked |=> $stable(own_addr) && addr_locked); // R4
endmodule

bind smb_strap_client smbc_check u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .idle_to(idle_to), .sda_oe(sda_oe), .reg_we(reg_we), .reg_ptr(reg_ptr),
  .own_addr(own_addr), .addr_locked(addr_locked)
);

// File: tb/test_smb_strap_client.sv
module test_smb_strap_client;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3;
  localparam int IDLE = 40;

  logic       clk = 0, rst_n = 0;
  logic [2:0] strap = 0;
  logic       scl = 1, hsda = 1;
  logic       sda_oe, reg_we;
  logic [7:0] reg_ptr, reg_wdata;
  logic [7:0] mem [256];
  wire        bus = hsda & ~sda_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_strap_client #(.SYNC_STAGES(2), .IDLE_CYC(IDLE)) i_smb_strap_client (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl), .sda_i(bus),
    .sda_oe(sda_oe), .reg_ptr(reg_ptr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(mem[reg_ptr])
  );

  always @(posedge clk) if (reg_we) mem[reg_ptr] <= reg_wdata;

  function automatic int fill(input int i); return (i * 37 + 11) & 255; endfunction
  function automatic logic [6:0] tbl(input int k);
    if (k == 7) return 7'h18;
    if (k < 4)  return 7'(7'h4C + k);
    return 7'(7'h49 + k - 4);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic do_reset(input logic [2:0] s);
    strap = s; rst_n = 0; scl = 1; hsda = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic start_c(); wq(); hsda = 1; wq(); scl = 1; wq(); hsda = 0; wq(); scl = 0; endtask
  task automatic stop_c();  wq(); hsda = 0; wq(); scl = 1; wq(); hsda = 1; wq(); endtask

  task automatic bit_io(input logic b, output logic got);
    wq(); hsda = b; wq(); scl = 1; wq(); got = bus; wq(); scl = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic g;
    for (int i = 7; i >= 0; i--) bit_io(b[i], g);
    bit_io(1'b1, g);
    ack = !g;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic host_nack);
    logic g;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, g); b[i] = g; end
    bit_io(host_nack, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    logic g;
    int v;
    for (int i = 0; i < 256; i++) mem[i] = 8'(fill(i));

    do_reset(3'd0);
    chk(sda_oe == 0 && reg_we == 0 && reg_ptr == 0, "R10 reset state",
        {sda_oe, reg_we, reg_ptr}, 0);

    // R3: each strap code acks only its own table entry
    for (int s = 0; s < 8; s++) begin
      do_reset(3'(s));
      for (int k = 0; k < 8; k++) begin
        start_c(); send_byte({tbl(k), 1'b0}, ack); stop_c();
        chk(ack == (k == s), "R3 strap table", ack, k == s);
      end
    end

    // R2/R5: all 128 addresses with strap 3
    do_reset(3'd3);
    for (int a = 0; a < 128; a++) begin
      start_c(); send_byte({7'(a), 1'b0}, ack);
      if (a != 'h4F) begin
        send_byte(8'h00, ack);
        chk(!ack, "R5 mismatch stays silent", ack, 0);
      end else chk(ack, "R2 address sweep match", ack, 1);
      stop_c();
    end

    // R4: strap change after reset ignored
    strap = 3'd0;
    start_c(); send_byte({7'h4C, 1'b0}, ack); stop_c();
    chk(!ack, "R4 new strap ignored", ack, 0);
    start_c(); send_byte({7'h4F, 1'b0}, ack); stop_c();
    chk(ack, "R4 latched strap kept", ack, 1);

    // R6: pointer then three data bytes
    start_c(); send_byte({7'h4F, 1'b0}, ack);
    send_byte(8'h10, ack); chk(ack, "R6 pointer byte ack", ack, 1);
    send_byte(8'hA5, ack); chk(ack, "R6 data ack", ack, 1);
    send_byte(8'h5A, ack); send_byte(8'h3C, ack);
    stop_c();
    chk(mem[16] == 8'hA5 && mem[17] == 8'h5A && mem[18] == 8'h3C, "R6 writes",
        {mem[16], mem[17], mem[18]}, 24'hA55A3C);
    chk(reg_ptr == 8'h13, "R6 pointer after writes", reg_ptr, 8'h13);
    chk(mem[19] == 8'(fill(19)), "R6 no extra write", mem[19], fill(19));

    // R1/R7: set pointer, repeated start, read across wrap
    start_c(); send_byte({7'h4F, 1'b0}, ack); send_byte(8'hFE, ack);
    start_c(); send_byte({7'h4F, 1'b1}, ack);
    chk(ack, "R1 repeated start read ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(b, i == 3);
      v = fill((254 + i) & 255);
      chk(b == 8'(v), "R7 read data", b, v);
    end
    chk(reg_ptr == 8'h02, "R7 pointer wrap", reg_ptr, 2);
    // R8: after host nack, line follows host only
    recv_byte(b, 1'b1);
    chk(b == 8'hFF, "R8 silent after nack", b, 8'hFF);
    stop_c();

    // R9: stop inside data byte writes nothing
    start_c(); send_byte({7'h4F, 1'b0}, ack); send_byte(8'h40, ack);
    for (int i = 0; i < 4; i++) bit_io(1'b0, g);
    stop_c();
    chk(mem[64] == 8'(fill(64)), "R9 partial byte dropped", mem[64], fill(64));
    start_c();
    for (int i = 6; i >= 3; i--) bit_io(1'(7'h4F >> i), g);
    stop_c();
    start_c(); send_byte({7'h4F, 1'b0}, ack); stop_c();
    chk(ack, "R9 idle after stop in address", ack, 1);

    // R11: clock held high in the ack slot
    start_c();
    for (int i = 7; i >= 0; i--) bit_io(1'(8'h9E >> i), g);
    wq(); hsda = 1; wq(); scl = 1; wq();
    chk(bus == 0, "R5 ack held in ninth clock", bus, 0);
    repeat (IDLE + 8) @(negedge clk);
    chk(bus == 1, "R11 released after stall", bus, 1);
    wq(); scl = 0;
    send_byte(8'h00, ack);
    chk(!ack, "R11 idle after stall", ack, 0);
    stop_c();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule